// File: doc/BRIEF.md
# Ultra DMA Device Write Receiver

This block sits on the device side of a parallel disk interface. It receives a host-to-device Ultra DMA burst. The host clocks 16-bit words with both edges of its strobe. The receiver turns each edge into one word on a single-cycle valid stream toward the device buffer, and folds every word into a running CRC-16.

The block drives the DMA request and an active-low ready line. It withdraws ready when the buffer runs short and keeps taking the words the host still has in flight. When the host raises STOP, the block drops the request and withdraws ready. It then treats any further strobe edge as carrying no data. It captures the host's CRC word when DMACK- goes high and raises an error flag if that word differs from the local CRC.

The strobe, STOP, DMACK- and data bus are registered through a short synchronizer chain. This keeps them aligned with each other before edge detection.

Top module: `udma_wr_rx`

## Requirements
- R1: While idle, `dmarq_o` follows `xfer_req_i` one cycle later. A burst starts when DMACK- falls while `dmarq_o` is high, and ready (`rdy_no_o` low) is asserted at that point.
- R2: During a burst, every rising or falling edge of `hstrobe_i` produces exactly one pulse on `wr_valid_o`, with `wr_data_o` equal to the `dd_i` value present at that edge.
- R3: The local CRC is seeded to 16'h4ABA at burst start. For every captured word it is advanced with polynomial 16'h1021, feeding data bit 0 first. The feedback is CRC bit 15 XOR the data bit, and the CRC shifts left.
- R4: Ready is withdrawn (`rdy_no_o` high) only after at least one word of the current burst has been captured and while `buf_free_i` <= HEADROOM (2). It is asserted again once `buf_free_i` > HEADROOM.
- R5: Strobe edges that arrive after ready has been withdrawn are still captured as words, with no loss.
- R6: After `stop_i` rises during a burst, `dmarq_o` is low within T_LI (4) cycles. It stays low until DMACK- has gone high.
- R7: Once STOP has been seen, ready stays withdrawn until the burst has ended.
- R8: Strobe edges after STOP has been seen produce no word and leave the CRC unchanged.
- R9: On the rising edge of DMACK- after STOP, `dd_i` is taken as the host CRC. `crc_err_o` is set when it differs from the local CRC and cleared when it matches. The flag holds until the next burst starts, which clears it.
- R10: After reset, `dmarq_o`=0, `rdy_no_o`=1, `wr_valid_o`=0 and `crc_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_req_i | input | 1 | Device wishes to receive a burst |
| dmack_ni | input | 1 | Host DMA acknowledge, active low |
| stop_i | input | 1 | Host stop request |
| hstrobe_i | input | 1 | Host data strobe, both edges carry data |
| dd_i | input | DW (16) | Host data bus |
| buf_free_i | input | FREE_W (6) | Free word slots in the device buffer |
| dmarq_o | output | 1 | DMA request |
| rdy_no_o | output | 1 | Device ready, active low |
| wr_valid_o | output | 1 | One-cycle pulse per captured word |
| wr_data_o | output | DW (16) | Captured word |
| crc_err_o | output | 1 | Host CRC mismatch |

## Verification
A wrong state register shows up within a few cycles of the next host action. A burst stuck active keeps `dmarq_o` high after STOP, past the T_LI bound. A lost or doubled strobe edge changes the word count seen on `wr_valid_o`. A CRC seed, polynomial or bit-order fault, or a CRC updated by the termination strobe, shows as `crc_err_o` at the rise of DMACK-, about three cycles after that edge. Pause faults appear as `rdy_no_o` rising before any word arrived, or not falling again once buffer room returns.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;
  localparam int CRC_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_TERM  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/udma_crc16.sv
module udma_crc16
  import udma_rx_pkg::*;
#(
  parameter int               DW   = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [DW-1:0]    data_i,
  output logic [CRC_W-1:0] crc_o
);
  // bit 0 of the word enters first
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_i;
    for (int i = 0; i < DW; i++) begin
      fb = c[CRC_W-1] ^ data_i[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_o = c;
  end
endmodule

// File: rtl/udma_wr_rx.sv
module udma_wr_rx
  import udma_rx_pkg::*;
#(
  parameter int               DW          = 16,
  parameter int               FREE_W      = 6,
  parameter int               HEADROOM    = 2,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CRC_W-1:0] CRC_SEED    = 16'h4ABA,
  parameter logic [CRC_W-1:0] CRC_POLY    = 16'h1021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_req_i,
  input  logic              dmack_ni,
  input  logic              stop_i,
  input  logic              hstrobe_i,
  input  logic [DW-1:0]     dd_i,
  input  logic [FREE_W-1:0] buf_free_i,
  output logic              dmarq_o,
  output logic              rdy_no_o,
  output logic              wr_valid_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              crc_err_o
);
  localparam int CTL_W = 3;

  logic [CTL_W-1:0] ctl_s;
  logic [DW-1:0]    dd_s;
  logic             strb_s, dmk_s, stop_s;
  logic             strb_prev_q, dmk_prev_q;
  logic             strb_edge, dmk_fall, dmk_rise, low_room;

  rx_state_e        state_q;
  logic             dmarq_q, rdy_nq, got_word_q, valid_q, err_q;
  logic [DW-1:0]    data_q;
  logic [CRC_W-1:0] crc_q, crc_nxt;

  // control bits: {stop, dmack_n, strobe}; dmack_n idles high
  udma_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({stop_i, dmack_ni, hstrobe_i}),
    .q_o   (ctl_s)
  );

  // data delayed by the same depth to stay aligned with the strobe
  udma_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dd_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dd_i),
    .q_o   (dd_s)
  );

  udma_crc16 #(.DW(DW), .POLY(CRC_POLY)) u_crc (
    .crc_i (crc_q),
    .data_i(dd_s),
    .crc_o (crc_nxt)
  );

  assign strb_s = ctl_s[0];
  assign dmk_s  = ctl_s[1];
  assign stop_s = ctl_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_prev_q <= 1'b0;
      dmk_prev_q  <= 1'b1;
    end else begin
      strb_prev_q <= strb_s;
      dmk_prev_q  <= dmk_s;
    end
  end

  assign strb_edge = strb_s ^ strb_prev_q;
  assign dmk_fall  = dmk_prev_q & ~dmk_s;
  assign dmk_rise  = ~dmk_prev_q & dmk_s;
  assign low_room  = buf_free_i <= FREE_W'(HEADROOM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      dmarq_q    <= 1'b0;
      rdy_nq     <= 1'b1;
      got_word_q <= 1'b0;
      valid_q    <= 1'b0;
      data_q     <= '0;
      crc_q      <= CRC_SEED;
      err_q      <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          dmarq_q <= xfer_req_i;
          rdy_nq  <= 1'b1;
          if (dmarq_q && dmk_fall) begin
            state_q    <= ST_BURST;
            dmarq_q    <= 1'b1;
            rdy_nq     <= 1'b0;
            got_word_q <= 1'b0;
            crc_q      <= CRC_SEED;
            err_q      <= 1'b0;
          end
        end
        ST_BURST: begin
          if (stop_s) begin
            state_q <= ST_TERM;
            dmarq_q <= 1'b0;
            rdy_nq  <= 1'b1;
          end else if (dmk_rise) begin
            state_q <= ST_IDLE;
            dmarq_q <= 1'b0;
            rdy_nq  <= 1'b1;
          end else begin
            if (strb_edge) begin
              valid_q    <= 1'b1;
              data_q     <= dd_s;
              crc_q      <= crc_nxt;
              got_word_q <= 1'b1;
            end
            // pause only once a word has arrived; late words still accepted
            rdy_nq <= rdy_nq ? low_room : (got_word_q && low_room);
          end
        end
        ST_TERM: begin
          dmarq_q <= 1'b0;
          rdy_nq  <= 1'b1;
          // final strobe edge carries no data: ignored here
          if (dmk_rise) begin
            err_q   <= (dd_s != crc_q);
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dmarq_o    = dmarq_q;
  assign rdy_no_o   = rdy_nq;
  assign wr_valid_o = valid_q;
  assign wr_data_o  = data_q;
  assign crc_err_o  = err_q;
endmodule

// File: rtl/udma_wr_rx_chk.sv
module udma_wr_rx_chk #(
  parameter int T_LI = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_i,
  input logic dmack_ni,
  input logic dmarq_o,
  input logic rdy_no_o,
  input logic wr_valid_o
);
  logic       seen_q;
  logic [7:0] li_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= 1'b0;
      li_cnt_q <= '0;
    end else begin
      if (dmack_ni)        seen_q <= 1'b0;
      else if (wr_valid_o) seen_q <= 1'b1;
      if (stop_i && dmarq_o && !dmack_ni) li_cnt_q <= li_cnt_q + 8'd1;
      else                                li_cnt_q <= '0;
    end
  end

  AST_PAUSE_AFTER_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rdy_no_o) && !stop_i && !dmack_ni) |-> seen_q); // R4
  AST_WORD_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(dmarq_o)); // R2
  AST_DMARQ_DROP_TLI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    li_cnt_q <= 8'(T_LI)); // R6
  AST_DMARQ_STAY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dmarq_o && stop_i && !dmack_ni) |=> !dmarq_o); // R6
  AST_READY_ONLY_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no_o |-> dmarq_o); // R7
endmodule

bind udma_wr_rx udma_wr_rx_chk #(.T_LI(4)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stop_i    (stop_i),
  .dmack_ni  (dmack_ni),
  .dmarq_o   (dmarq_o),
  .rdy_no_o  (rdy_no_o),
  .wr_valid_o(wr_valid_o)
);

// File: tb/udma_wr_rx_bench.sv
`timescale 1ns/1ps
module udma_wr_rx_bench;
  localparam int T_LI = 4;
  localparam int NW   = 8;
  localparam logic [15:0] WORDS [NW] = '{16'h0000, 16'hFFFF, 16'h1234, 16'hA5A5,
                                         16'h8001, 16'h5A5A, 16'h00FF, 16'hBEEF};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_req_i = 1'b0, dmack_ni = 1'b1, stop_i = 1'b0, hstrobe_i = 1'b0;
  logic [15:0] dd_i = '0;
  logic [5:0]  buf_free_i = 6'd20;
  logic        dmarq_o, rdy_no_o, wr_valid_o, crc_err_o;
  logic [15:0] wr_data_o;

  int          n_run = 0, n_fail = 0, n_words = 0;
  logic [15:0] got [64];
  logic [15:0] crc_m;
  bit          done = 0;

  always #5 clk_i = ~clk_i;

  udma_wr_rx u_udma_wr_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .xfer_req_i(xfer_req_i), .dmack_ni(dmack_ni),
    .stop_i(stop_i), .hstrobe_i(hstrobe_i), .dd_i(dd_i), .buf_free_i(buf_free_i),
    .dmarq_o(dmarq_o), .rdy_no_o(rdy_no_o), .wr_valid_o(wr_valid_o),
    .wr_data_o(wr_data_o), .crc_err_o(crc_err_o)
  );

  always @(negedge clk_i) if (wr_valid_o && n_words < 64) begin
    got[n_words] = wr_data_o;
    n_words++;
  end

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [15:0] d);
    for (int i = 0; i < 16; i++) begin
      if (c[15] ^ d[i]) c = (c << 1) ^ 16'h1021;
      else              c = c << 1;
    end
    return c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_word(logic [15:0] w);
    dd_i = w;
    hstrobe_i = ~hstrobe_i;
    crc_m = crc_step(crc_m, w);
    cyc(5);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int base, cnt;
    cyc(3);
    // R10 reset state
    check("R10 dmarq", dmarq_o, 0);
    check("R10 rdy_n", rdy_no_o, 1);
    check("R10 valid", wr_valid_o, 0);
    check("R10 err", crc_err_o, 0);
    rst_ni = 1'b1;
    cyc(2);

    // R1 request and burst start
    xfer_req_i = 1'b1;
    cyc(2);
    check("R1 dmarq follows req", dmarq_o, 1);
    dmack_ni = 1'b0;
    cyc(6);
    check("R1 ready at burst start", rdy_no_o, 0);

    // R2/R3 table-driven burst
    crc_m = 16'h4ABA;
    for (int k = 0; k < NW; k++) send_word(WORDS[k]);
    check("R2 word count", n_words, NW);
    for (int k = 0; k < NW; k++) check("R2 word data", got[k], WORDS[k]);

    // R6/R7 stop
    stop_i = 1'b0;
    @(negedge clk_i) stop_i = 1'b1;
    cnt = 0;
    while (dmarq_o && cnt < 10) begin cyc(1); cnt++; end
    check("R6 dmarq drop within T_LI", (cnt <= T_LI), 1);
    check("R7 ready withdrawn", rdy_no_o, 1);
    // R8 final strobe edge carries no data
    dd_i = 16'hDEAD;
    hstrobe_i = ~hstrobe_i;
    cyc(6);
    check("R8 no word after stop", n_words, NW);
    check("R6 dmarq held low", dmarq_o, 0);
    check("R7 ready still withdrawn", rdy_no_o, 1);
    // R3/R9 correct host CRC
    dd_i = crc_m;
    dmack_ni = 1'b1;
    cyc(6);
    check("R3 R9 matching CRC", crc_err_o, 0);
    stop_i = 1'b0;
    cyc(3);

    // R4/R5 pause in second burst
    buf_free_i = 6'd0;
    crc_m = 16'h4ABA;
    dmack_ni = 1'b0;
    cyc(8);
    check("R4 no pause before first word", rdy_no_o, 0);
    base = n_words;
    send_word(16'h1111);
    check("R4 pause after word", rdy_no_o, 1);
    send_word(16'h2222);
    send_word(16'h3333);
    send_word(16'h4444);
    check("R5 late words accepted", n_words - base, 4);
    check("R5 last late word", got[base+3], 16'h4444);
    buf_free_i = 6'd3;
    cyc(4);
    check("R4 resume on room", rdy_no_o, 0);
    buf_free_i = 6'd2;
    cyc(4);
    check("R4 pause at headroom", rdy_no_o, 1);
    buf_free_i = 6'd20;
    stop_i = 1'b1;
    cyc(6);
    dd_i = crc_m ^ 16'h0001;
    dmack_ni = 1'b1;
    cyc(6);
    check("R9 mismatch flagged", crc_err_o, 1);
    stop_i = 1'b0;
    cyc(10);
    check("R9 flag held while idle", crc_err_o, 1);

    // third burst: flag clears, single-word CRC
    crc_m = 16'h4ABA;
    dmack_ni = 1'b0;
    cyc(6);
    check("R9 flag cleared at burst start", crc_err_o, 0);
    send_word(16'hC001);
    stop_i = 1'b1;
    cyc(6);
    dd_i = crc_m;
    dmack_ni = 1'b1;
    cyc(6);
    check("R3 single-word CRC", crc_err_o, 0);
    stop_i = 1'b0;

    done = 1;
    finish_run();
  end
endmodule